// File: doc/BRIEF.md
# Four-Function ALU with Condition Codes

This block is a small arithmetic-logic unit with a registered compare result beside it. Two unsigned operands feed four function circuits that all work at once: a wrapping adder, a wrapping subtractor, a word-equality detector and a bitwise AND. A two-bit function code steers an output multiplexer that passes one of the four results to the output. The output path is purely combinational, so a new operand or function code shows at the output in the same cycle, with no clock edge needed.

A separate compare strobe loads a three-flag condition register on the rising clock edge. The flags say whether the first operand is greater than, equal to, or less than the second. Exactly one flag is set after each compare. Between compares the register keeps its value, whatever the operands and function code do. The register is what a branch unit would look at to decide on a conditional jump.

The operand width is a parameter with a default of 4. Two further parameters pick the adder structure, behavioural or ripple-carry, and the equality variant, whole-word or per-bit.

Top module: `alu_cc_unit`

## Requirements
- R1: The function code selects the output as follows: 2'b00 passes the sum, 2'b01 the difference, 2'b10 the equality result, and 2'b11 the AND result. With A=4'b1001 and B=4'b0011 these give 4'b1100, 4'b0110, 4'b0000 and 4'b0001.
- R2: The sum is A+B modulo 2^WIDTH, and any carry out of the top bit is discarded.
- R3: The difference is A-B modulo 2^WIDTH, so A<B wraps around (for example 3-9 gives 4'b1010).
- R4: In the default whole-word variant the equality result is all ones when A equals B and all zeros otherwise.
- R5: The AND result is the bit-by-bit AND of A and B.
- R6: All four results are computed continuously. Changing only the function code between clock edges changes the output at once and leaves the flags untouched.
- R7: On a clock edge with the compare strobe high and reset low, the flags load {GT,EQ,LT} for an unsigned compare of A against B. The encodings are 3'b100 for A>B, 3'b010 for A==B and 3'b001 for A<B, so exactly one flag is set.
- R8: On an edge with the compare strobe low, the flags keep their previous value, whatever the operands.
- R9: A synchronous active-high reset clears the flags to 3'b000. Reset takes priority over a compare strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opnd_a | input | 4 | First operand (WIDTH bits) |
| opnd_b | input | 4 | Second operand (WIDTH bits) |
| fn_sel | input | 2 | Function code for the output multiplexer |
| cmp_strobe | input | 1 | Loads the compare outcome on the next rising edge |
| result | output | 4 | Selected function result (WIDTH bits) |
| cc_flags | output | 3 | Condition flags {GT,EQ,LT} |

## Verification
The bench checks the wrap cases of the adder and subtractor, such as 4'hF+1 and 0-1. A design that kept a fifth bit or saturated would show a non-zero or clamped result there. It compares operands whose top bit differ, such as 2 against 4'hC. A signed compare would report greater-than where less-than is correct. It runs equality with identical and with partly matching operands, which exposes a per-bit match vector used in place of the whole-word flag. It also asserts reset together with the strobe and leaves the strobe low while the operands change. A register that ignored reset priority or loaded without the strobe would then show the wrong flags.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

   typedef enum logic [1:0] {
      FN_ADD = 2'b00,
      FN_SUB = 2'b01,
      FN_EQ  = 2'b10,
      FN_AND = 2'b11
   } alu_fn_e;

   localparam int unsigned NUM_FUNCS = 4;

   // gt is bit 2, eq bit 1, lt bit 0: 100 / 010 / 001
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } cc_flags_t;

   localparam cc_flags_t CC_CLEAR = '{gt: 1'b0, eq: 1'b0, lt: 1'b0};

endpackage

// File: rtl/alu_func_bank.sv
module alu_func_bank #(
   parameter int unsigned WIDTH        = 4,
   parameter bit          RIPPLE_ADDER = 1'b1,
   parameter bit          EQ_PER_BIT   = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] diff_o,
   output logic [WIDTH-1:0] eq_o,
   output logic [WIDTH-1:0] and_o
);

   initial begin
      assert (WIDTH >= 1) else $error("alu_func_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] b_inv;
   logic [WIDTH-1:0] match_bits;

   // per-bit match and AND cells
   for (genvar i = 0; i < WIDTH; i++) begin : g_bitcell
      assign match_bits[i] = ~(a[i] ^ b[i]);
      assign and_o[i]      = a[i] & b[i];
      assign b_inv[i]      = ~b[i];
   end

   // equality variant
   if (EQ_PER_BIT) begin : g_eq_bitwise
      assign eq_o = match_bits;
   end else begin : g_eq_word
      assign eq_o = {WIDTH{&match_bits}};
   end

   // adder / subtractor variant
   if (RIPPLE_ADDER) begin : g_ripple
      logic [WIDTH-1:0] c_add;
      logic [WIDTH-1:0] c_sub;
      assign c_add[0] = 1'b0;
      assign c_sub[0] = 1'b1;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign sum_o[i]  = a[i] ^ b[i] ^ c_add[i];
         assign diff_o[i] = a[i] ^ b_inv[i] ^ c_sub[i];
         if (i < WIDTH - 1) begin : g_carry
            assign c_add[i+1] = (a[i] & b[i])     | (c_add[i] & (a[i] ^ b[i]));
            assign c_sub[i+1] = (a[i] & b_inv[i]) | (c_sub[i] & (a[i] ^ b_inv[i]));
         end
      end
   end else begin : g_behav
      assign sum_o  = a + b;
      assign diff_o = a - b;
   end

   always_comb begin
      if (!$isunknown({a, b})) begin
         assert_sum_wrap_R2: assert (WIDTH'(sum_o - b) == a)
            else $error("sum does not wrap modulo 2^WIDTH");
         assert_diff_wrap_R3: assert (WIDTH'(diff_o + b) == a)
            else $error("difference does not wrap modulo 2^WIDTH");
         assert_and_subset_R5: assert (((and_o & ~a) == '0) && ((and_o & ~b) == '0))
            else $error("AND result sets bits absent from an operand");
         if (!EQ_PER_BIT) begin
            assert_eq_word_R4: assert ((eq_o == {WIDTH{1'b1}}) == (a == b))
               else $error("word equality result disagrees with operands");
         end
      end
   end

endmodule

// File: rtl/alu_out_mux.sv
module alu_out_mux
   import alu_cc_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  alu_fn_e          sel,
   input  logic [WIDTH-1:0] sum_i,
   input  logic [WIDTH-1:0] diff_i,
   input  logic [WIDTH-1:0] eq_i,
   input  logic [WIDTH-1:0] and_i,
   output logic [WIDTH-1:0] y
);

   localparam int unsigned SEL_W = $clog2(NUM_FUNCS);

   logic [WIDTH-1:0] lanes [NUM_FUNCS];
   logic [SEL_W-1:0] idx;

   assign lanes[FN_ADD] = sum_i;
   assign lanes[FN_SUB] = diff_i;
   assign lanes[FN_EQ]  = eq_i;
   assign lanes[FN_AND] = and_i;
   assign idx           = sel;

   // and-or tree: each lane gated by its decoded select line
   logic [NUM_FUNCS-1:0] dec;
   logic [WIDTH-1:0]     gated [NUM_FUNCS];

   for (genvar k = 0; k < NUM_FUNCS; k++) begin : g_lane
      assign dec[k]   = (idx == SEL_W'(k));
      assign gated[k] = lanes[k] & {WIDTH{dec[k]}};
   end

   always_comb begin
      y = '0;
      for (int k = 0; k < NUM_FUNCS; k++) begin
         y = y | gated[k];
      end
   end

   always_comb begin
      if (!$isunknown(sel)) begin
         assert_one_lane_R1: assert ($onehot(dec))
            else $error("output multiplexer did not pick exactly one lane");
      end
   end

endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
   import alu_cc_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             strobe,
   output cc_flags_t        flags
);

   cc_flags_t outcome;

   always_comb begin
      outcome.gt = (a > b);
      outcome.eq = (a == b);
      outcome.lt = (a < b);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flags <= CC_CLEAR;
      end else if (strobe) begin
         flags <= outcome;
      end
   end

   assert_one_flag_R7: assert property (@(posedge clk) disable iff (rst)
      strobe |=> ($countones(flags) == 1))
      else $error("compare left other than one flag set");

   assert_eq_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (strobe && (a == b)) |=> (flags == 3'b010))
      else $error("equal operands did not give EQ");

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(flags))
      else $error("flags changed without a compare");

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (flags == 3'b000))
      else $error("reset did not clear flags");

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
   import alu_cc_pkg::*;
#(
   parameter int unsigned WIDTH        = 4,
   parameter bit          RIPPLE_ADDER = 1'b1,
   parameter bit          EQ_PER_BIT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       fn_sel,
   input  logic             cmp_strobe,
   output logic [WIDTH-1:0] result,
   output logic [2:0]       cc_flags
);

   initial begin
      assert (WIDTH >= 1 && WIDTH <= 64) else $error("alu_cc_unit: WIDTH out of range");
   end

   logic [WIDTH-1:0] sum_w, diff_w, eq_w, and_w;
   cc_flags_t        flags_w;

   alu_func_bank #(
      .WIDTH        (WIDTH),
      .RIPPLE_ADDER (RIPPLE_ADDER),
      .EQ_PER_BIT   (EQ_PER_BIT)
   ) u_funcs (
      .a      (opnd_a),
      .b      (opnd_b),
      .sum_o  (sum_w),
      .diff_o (diff_w),
      .eq_o   (eq_w),
      .and_o  (and_w)
   );

   alu_out_mux #(
      .WIDTH (WIDTH)
   ) u_mux (
      .sel    (alu_fn_e'(fn_sel)),
      .sum_i  (sum_w),
      .diff_i (diff_w),
      .eq_i   (eq_w),
      .and_i  (and_w),
      .y      (result)
   );

   cc_flag_reg #(
      .WIDTH (WIDTH)
   ) u_flags (
      .clk    (clk),
      .rst    (rst),
      .a      (opnd_a),
      .b      (opnd_b),
      .strobe (cmp_strobe),
      .flags  (flags_w)
   );

   assign cc_flags = flags_w;

endmodule

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] opnd_a = '0;
   logic [3:0] opnd_b = '0;
   logic [1:0] fn_sel = '0;
   logic       cmp_strobe = 1'b0;
   logic [3:0] result;
   logic [2:0] cc_flags;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   alu_cc_unit i_alu_cc_unit (
      .clk        (clk),
      .rst        (rst),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .fn_sel     (fn_sel),
      .cmp_strobe (cmp_strobe),
      .result     (result),
      .cc_flags   (cc_flags)
   );

   // {a, b, sel, expected}
   localparam int NVEC = 14;
   localparam logic [13:0] VEC [NVEC] = '{
      {4'h9, 4'h3, 2'd0, 4'hC},
      {4'h9, 4'h3, 2'd1, 4'h6},
      {4'h9, 4'h3, 2'd2, 4'h0},
      {4'h9, 4'h3, 2'd3, 4'h1},
      {4'hF, 4'h1, 2'd0, 4'h0},
      {4'h8, 4'h8, 2'd0, 4'h0},
      {4'h3, 4'h9, 2'd1, 4'hA},
      {4'h0, 4'h1, 2'd1, 4'hF},
      {4'h7, 4'h6, 2'd1, 4'h1},
      {4'h5, 4'h5, 2'd2, 4'hF},
      {4'h0, 4'h0, 2'd2, 4'hF},
      {4'hE, 4'h7, 2'd2, 4'h0},
      {4'hC, 4'hA, 2'd3, 4'h8},
      {4'hF, 4'hF, 2'd3, 4'hF}
   };

   function automatic string req_of(input logic [1:0] s);
      case (s)
         2'd0:    return "R1/R2";
         2'd1:    return "R1/R3";
         2'd2:    return "R1/R4";
         default: return "R1/R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_compare(input logic [3:0] a, input logic [3:0] b, input logic [2:0] exp);
      @(negedge clk);
      opnd_a = a; opnd_b = b; cmp_strobe = 1'b1;
      @(posedge clk);
      #1;
      cmp_strobe = 1'b0;
      check("R7 compare", 8'(cc_flags), 8'(exp));
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset state", 8'(cc_flags), 8'h0);
      @(negedge clk);
      rst = 1'b0;

      // table walk (combinational result)
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         opnd_a = VEC[i][13:10];
         opnd_b = VEC[i][9:6];
         fn_sel = VEC[i][5:4];
         #1;
         check(req_of(VEC[i][5:4]), 8'(result), 8'(VEC[i][3:0]));
      end

      // R7: unsigned compare outcomes
      do_compare(4'h9, 4'h3, 3'b100);
      do_compare(4'h3, 4'h3, 3'b010);
      do_compare(4'h2, 4'hC, 3'b001);
      do_compare(4'hF, 4'h0, 3'b100);

      // R8: strobe low, operands change, flags hold 100
      @(negedge clk);
      opnd_a = 4'h1; opnd_b = 4'h1;
      repeat (2) @(posedge clk);
      #1;
      check("R8 hold on equal operands", 8'(cc_flags), 8'h4);
      @(negedge clk);
      opnd_a = 4'h0; opnd_b = 4'h7;
      @(posedge clk);
      #1;
      check("R8 hold on smaller A", 8'(cc_flags), 8'h4);

      // R6: change only fn_sel between edges, no clock edge
      @(posedge clk);
      #0.5;
      opnd_a = 4'h6; opnd_b = 4'h3; fn_sel = 2'd0;
      #0.5;
      check("R6 sum between edges", 8'(result), 8'h9);
      fn_sel = 2'd1;
      #0.5;
      check("R6 diff between edges", 8'(result), 8'h3);
      fn_sel = 2'd3;
      #0.5;
      check("R6 and between edges", 8'(result), 8'h2);
      check("R6 flags untouched", 8'(cc_flags), 8'h4);

      // R9: reset wins over a strobe in the same cycle
      @(negedge clk);
      opnd_a = 4'h4; opnd_b = 4'h4; cmp_strobe = 1'b1; rst = 1'b1;
      @(posedge clk);
      #1;
      check("R9 reset priority", 8'(cc_flags), 8'h0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      cmp_strobe = 1'b0;
      check("R7 compare after reset", 8'(cc_flags), 8'h2);

      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule